// File: doc/BRIEF.md
# Valley-Skipping Turn-On Controller

This block decides the turn-on instant of the power switch in a quasi-resonant flyback converter. A digitized zero-crossing comparator output is synchronized and scanned for falling edges. After each turn-on, a blanking window rejects early edges. The first falling edge seen after the window arms a short valley delay, and the delay then turns the switch on. At light load the switch therefore skips ringing valleys, and the switching rate never goes above one over the blanking time.

A restart timer covers the case where no valid edge arrives, such as during start-up or when the output is too low during constant-current operation. The timer restarts on every turn-on. It fires after one of two periods, and the burst-threshold flag selects which one. The on-period ends on a termination request from the current loop or when a maximum on-time counter expires, whichever happens first. All intervals are parameters counted in clock cycles.

Top module: `qr_valley_ctrl`

## Requirements
- R1: `gate_out` is 0 while `rst` is high and in the cycle after any reset cycle. After reset is released with no zero-crossing edges, the first turn-on happens exactly START_FAST cycles later, or START_SLOW cycles later if `burst_low` is high.
- R2: With `burst_low` = 0 and no falling edge on `zc_in`, rising edges of `gate_out` are exactly START_FAST cycles apart.
- R3: With `burst_low` = 1 and no falling edge on `zc_in`, rising edges of `gate_out` are exactly START_SLOW cycles apart.
- R4: A falling edge of `zc_in` is ignored if it is first sampled low fewer than BLANK-2 cycles after a turn-on. The two cycles are synchronizer latency. Such an edge neither turns on the switch nor restarts any timer.
- R5: Take the first falling edge that qualifies, with `zc_in` first driven low in the cycle that is m cycles after the turn-on edge. `gate_out` then rises exactly m+3+VALLEY_DLY cycles after the previous turn-on.
- R6: Falling edges that occur while `gate_out` is high, or while the valley delay is running, do not change the timing of the next turn-on.
- R7: `ton_end` sampled high while `gate_out` is high drives `gate_out` low on that same clock edge. If `ton_end` is driven in cycle t after turn-on, the on-width is t+1 cycles.
- R8: Without `ton_end`, `gate_out` stays high for exactly MAX_ON cycles.
- R9: The restart timer clears on every turn-on, whether it came from a valley or from the timer. A starter turn-on therefore always comes a full starter period after the previous turn-on, and valley edges that arrive more often than that period keep the timer from firing.
- R10: `ton_end` asserted while `gate_out` is low has no effect on the gate or on the next turn-on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Zero-crossing comparator output, asynchronous, idles high |
| burst_low | input | 1 | High when the compensation level is below the burst threshold (selects the slow starter period) |
| ton_end | input | 1 | On-time termination request from the current loop |
| gate_out | output | 1 | Registered switch gate drive |

## Verification
Every internal counter in this block shows up at the ports as a shifted gate edge. An error in blanking, valley delay or starter count moves the next rising edge of `gate_out` by at least one cycle, within the same switching period. An error in the on-time counter changes the high width in that period. The bench measures each width and each rise-to-rise interval to the exact cycle. A stale synchronizer bit or a stuck delay flag appears as a missing turn-on or an extra turn-on within one starter period.

// File: rtl/qr_valley_pkg.sv
package qr_valley_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_VALLEY  = 2'd1,
    SRC_STARTER = 2'd2
  } turnon_src_e;
endpackage

// File: rtl/qr_zc_edge.sv
module qr_zc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_raw,
  output logic fall_pulse
);
  // chain_q[STAGES-1] is the last synchronizer flop, chain_q[STAGES] its delayed copy
  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= zc_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign fall_pulse = chain_q[STAGES] & ~chain_q[STAGES-1];

  // R5
  single_fall_chk: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/qr_valley_arm.sv
module qr_valley_arm #(
  parameter int BLANK      = 300,
  parameter int VALLEY_DLY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_pulse,
  input  logic gate_on,
  input  logic turn_on,
  output logic blank_done,
  output logic pending,
  output logic valley_fire
);
  localparam int BW = $clog2(BLANK + 1);
  localparam int DW = $clog2(VALLEY_DLY + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK);
  localparam logic [DW-1:0] DLY_END   = DW'(VALLEY_DLY - 1);

  logic [BW-1:0] blank_cnt_q;
  logic [DW-1:0] dly_cnt_q;
  logic          pending_q;

  // blanking window counted only from an actual turn-on
  always_ff @(posedge clk) begin
    if (rst)                       blank_cnt_q <= BLANK_END;
    else if (turn_on)              blank_cnt_q <= '0;
    else if (blank_cnt_q != BLANK_END) blank_cnt_q <= blank_cnt_q + 1'b1;
  end

  assign blank_done = (blank_cnt_q == BLANK_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      dly_cnt_q <= '0;
    end else if (turn_on) begin
      pending_q <= 1'b0;
      dly_cnt_q <= '0;
    end else if (!pending_q && fall_pulse && blank_done && !gate_on) begin
      pending_q <= 1'b1;
      dly_cnt_q <= '0;
    end else if (pending_q) begin
      dly_cnt_q <= dly_cnt_q + 1'b1;
    end
  end

  assign pending     = pending_q;
  assign valley_fire = pending_q && (dly_cnt_q == DLY_END);

  // R4
  armed_after_blank_chk: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> blank_done);

  // R5
  dly_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> (dly_cnt_q <= DLY_END));
endmodule

// File: rtl/qr_restart_timer.sv
module qr_restart_timer #(
  parameter int START_FAST = 6250,
  parameter int START_SLOW = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_low,
  input  logic turn_on,
  input  logic hold,
  output logic start_fire
);
  localparam int SW = $clog2(START_SLOW + 1);
  localparam logic [SW-1:0] FAST_END = SW'(START_FAST - 1);
  localparam logic [SW-1:0] SLOW_END = SW'(START_SLOW - 1);

  logic          burst_q;
  logic [SW-1:0] st_cnt_q;
  logic [SW-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst) burst_q <= 1'b0;
    else     burst_q <= burst_low;
  end

  always_ff @(posedge clk) begin
    if (rst)                       st_cnt_q <= '0;
    else if (turn_on)              st_cnt_q <= '0;
    else if (st_cnt_q != SLOW_END) st_cnt_q <= st_cnt_q + 1'b1;
  end

  assign limit      = burst_q ? SLOW_END : FAST_END;
  assign start_fire = !hold && (st_cnt_q >= limit);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    turn_on |=> (st_cnt_q == '0));
endmodule

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl
  import qr_valley_pkg::*;
#(
  parameter int BLANK      = 300,
  parameter int VALLEY_DLY = 10,
  parameter int MAX_ON     = 250,
  parameter int START_FAST = 6250,
  parameter int START_SLOW = 25000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_in,
  input  logic burst_low,
  input  logic ton_end,
  output logic gate_out
);
  localparam int OW = $clog2(MAX_ON + 1);
  localparam logic [OW-1:0] ON_END = OW'(MAX_ON - 1);

  logic          fall_pulse;
  logic          blank_done;
  logic          pending;
  logic          valley_fire;
  logic          start_fire;
  logic          turn_on;
  logic          gate_q;
  logic [OW-1:0] on_cnt_q;
  turnon_src_e   src;

  qr_zc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .zc_raw     (zc_in),
    .fall_pulse (fall_pulse)
  );

  qr_valley_arm #(.BLANK(BLANK), .VALLEY_DLY(VALLEY_DLY)) u_arm (
    .clk         (clk),
    .rst         (rst),
    .fall_pulse  (fall_pulse),
    .gate_on     (gate_q),
    .turn_on     (turn_on),
    .blank_done  (blank_done),
    .pending     (pending),
    .valley_fire (valley_fire)
  );

  qr_restart_timer #(.START_FAST(START_FAST), .START_SLOW(START_SLOW)) u_start (
    .clk        (clk),
    .rst        (rst),
    .burst_low  (burst_low),
    .turn_on    (turn_on),
    .hold       (gate_q | pending),
    .start_fire (start_fire)
  );

  always_comb begin
    if (valley_fire)     src = SRC_VALLEY;
    else if (start_fire) src = SRC_STARTER;
    else                 src = SRC_NONE;
  end

  assign turn_on = !gate_q && (src != SRC_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= 1'b0;
      on_cnt_q <= '0;
    end else if (turn_on) begin
      gate_q   <= 1'b1;
      on_cnt_q <= '0;
    end else if (gate_q && (ton_end || on_cnt_q == ON_END)) begin
      gate_q   <= 1'b0;
    end else if (gate_q) begin
      on_cnt_q <= on_cnt_q + 1'b1;
    end
  end

  assign gate_out = gate_q;

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !gate_out);

  // R4
  rise_after_blank_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_out) |-> $past(blank_done));

  // R6
  delay_gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    pending |-> !gate_out);

  // R7
  term_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_out && ton_end) |=> !gate_out);

  // R8
  on_bound_chk: assert property (@(posedge clk) disable iff (rst)
    gate_out |-> (on_cnt_q <= ON_END));
endmodule

// File: tb/qr_valley_ctrl_tb.sv
`timescale 1ns/1ps
module qr_valley_ctrl_tb_top;
  localparam int BLANK      = 40;
  localparam int VALLEY_DLY = 4;
  localparam int MAX_ON     = 30;
  localparam int START_FAST = 200;
  localparam int START_SLOW = 600;
  localparam int LIMIT      = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zc_in = 1'b1;
  logic burst_low = 1'b0;
  logic ton_end = 1'b0;
  logic gate_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qr_valley_ctrl #(
    .BLANK(BLANK), .VALLEY_DLY(VALLEY_DLY), .MAX_ON(MAX_ON),
    .START_FAST(START_FAST), .START_SLOW(START_SLOW), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .zc_in(zc_in), .burst_low(burst_low),
    .ton_end(ton_end), .gate_out(gate_out)
  );

  function automatic int exp_width(input int t);
    return (t >= 0 && t < MAX_ON) ? t + 1 : MAX_ON;
  endfunction

  function automatic int exp_ival(input int m, input bit slow);
    if (m >= 0) return m + 3 + VALLEY_DLY;
    return slow ? START_SLOW : START_FAST;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at the negedge right after a rising gate edge; ends at the negedge after the next one.
  // e: early fall (3 low cycles), m: qualifying fall (2 low cycles), dbl: extra fall in delay window
  task automatic run_period(input int e, input int m, input bit dbl, input int t,
                            output int width, output int ival);
    width = -1;
    ival  = -1;
    for (int i = 0; i <= LIMIT; i++) begin
      if (i > 0) begin
        @(negedge clk);
        if (width < 0 && !gate_out) width = i;
        else if (width >= 0 && gate_out) begin
          ival = i;
          break;
        end
      end
      zc_in = !((e >= 0 && i >= e && i <= e + 2) ||
                (m >= 0 && i >= m && i <= m + 1) ||
                (dbl && m >= 0 && i >= m + 3 && i <= m + 4));
      ton_end = (i == t);
    end
    zc_in = 1'b1;
    ton_end = 1'b0;
  endtask

  task automatic wait_first_rise(output int cnt);
    cnt = -1;
    for (int j = 1; j <= LIMIT; j++) begin
      @(negedge clk);
      if (gate_out) begin
        cnt = j;
        break;
      end
    end
  endtask

  task automatic period_check(input string rw, input string ri, input int e, input int m,
                              input bit dbl, input int t);
    int w;
    int iv;
    run_period(e, m, dbl, t, w, iv);
    check(rw, w, exp_width(t));
    check(ri, iv, exp_ival(m, burst_low));
  endtask

  initial begin
    int c;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    n_checks++;
    if (gate_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset gate actual=%0b expected=0", gate_out);
    end
    rst = 1'b0;
    // R1: first starter turn-on after reset
    wait_first_rise(c);
    check("R1", c, START_FAST);

    // R2 / R8: plain starter periods with maximum on-time
    period_check("R8", "R2", -1, -1, 1'b0, -1);
    period_check("R8", "R2", -1, -1, 1'b0, -1);

    // R7: termination request
    period_check("R7", "R2", -1, -1, 1'b0, 5);
    period_check("R7", "R2", -1, -1, 1'b0, 0);

    // R10: termination while gate already low
    period_check("R10", "R10", -1, -1, 1'b0, MAX_ON + 5);
    period_check("R10", "R10", -1, BLANK + 2, 1'b0, BLANK + 1);

    // R4: early edges only -> starter period, not a valley turn-on
    period_check("R8", "R4", BLANK - 5, -1, 1'b0, -1);
    period_check("R8", "R4", 3, -1, 1'b0, -1);

    // R5: first qualifying edge, boundary and beyond
    period_check("R8", "R5", -1, BLANK - 2, 1'b0, -1);
    period_check("R8", "R5", -1, BLANK + 17, 1'b0, -1);

    // R6: edge while gate high plus extra edge in the delay window
    period_check("R7", "R6", 4, BLANK + 3, 1'b1, 10);
    period_check("R8", "R6", BLANK - 6, BLANK + 1, 1'b1, -1);

    // R9: starter measured from a valley turn-on
    period_check("R8", "R9", -1, -1, 1'b0, -1);

    // R3: slow starter period
    burst_low = 1'b1;
    period_check("R8", "R3", -1, -1, 1'b0, -1);
    period_check("R7", "R3", -1, -1, 1'b0, 12);
    burst_low = 1'b0;
    period_check("R8", "R2", -1, -1, 1'b0, -1);

    // Random mix; valley edges always arrive before the starter (R9)
    for (int k = 0; k < 40; k++) begin
      int e;
      int m;
      int t;
      bit dbl;
      e   = ($urandom % 3 == 0) ? -1 : int'($urandom % (BLANK - 8)) + 1;
      m   = BLANK + int'($urandom % 40);
      t   = ($urandom % 2 == 0) ? -1 : int'($urandom % (MAX_ON + 10));
      dbl = ($urandom % 2 == 1);
      period_check("R7", "R9", e, m, dbl, t);
    end

    // R1: reset during an on-period
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'(gate_out), 0);
    rst = 1'b0;
    wait_first_rise(c);
    check("R1", c, START_FAST);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 64'd20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule